// File: doc/BRIEF.md
# Bounded Descending Stack Pointer Unit

This block owns the hardware stack pointer of a 16-bit, byte-addressed, big-endian machine. A client issues a one-cycle request to push a word, pop a word, push the two-word interrupt-entry frame, or pop that frame on return. The unit checks the request against a fixed 256-byte stack window, moves the pointer in steps of two bytes, and turns each 16-bit word into two byte transfers on an 8-bit memory port, high byte at the lower address.

A request that would leave the window is refused at once. It makes no memory access, leaves the pointer where it was, and raises a one-cycle fault pulse with a code that tells overflow from underflow. A two-word frame is checked as a whole, so a frame that would not fit is refused without a partial push or pop. The memory array and the fetching of interrupt vectors sit outside this block.

Top module: `stk_unit`

## Requirements
- R1: After reset the pointer reads 0xFE00 (empty stack), busy is low, and no fault or pop-data pulse is present.
- R2: A push (reqOp 0) lowers the pointer by 2 at the accepting clock edge, then writes the high byte of the word at the new pointer in the first busy cycle and the low byte at pointer+1 in the second.
- R3: A pop (reqOp 1) reads the high byte at the pointer and then the low byte at pointer+1; after the second read, popValid pulses for one cycle with the assembled word and the pointer has risen by 2.
- R4: A push or frame push with too little room raises faultValid for one cycle with faultCode 1 (overflow), makes no memory access and leaves the pointer unchanged; a single push needs the pointer at 0xFD02 or above.
- R5: A pop with the pointer at or above 0xFE00, or a frame pop with the pointer at or above 0xFDFE, raises faultValid for one cycle with faultCode 2 (underflow), makes no memory access and leaves the pointer unchanged.
- R6: A frame push (reqOp 2) stores pushFlags as the first word and pushData as the second, lowering the pointer by 4 in all; it is refused as an overflow when the pointer is below 0xFD04.
- R7: A frame pop (reqOp 3) delivers two popValid pulses, the return address first and the flag word second, raising the pointer by 4.
- R8: busy is high from the cycle after an accepted request until the last byte transfer; a request presented while busy is ignored.
- R9: The window holds exactly 128 words: 128 pushes from empty succeed, the next push faults, 128 pops return the words in reverse order, and the next pop faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, sampled only when idle |
| reqOp | input | 2 | 0 push, 1 pop, 2 frame push, 3 frame pop |
| pushData | input | 16 | Word to push; return address for a frame push |
| pushFlags | input | 16 | Flag word for a frame push |
| busy | output | 1 | Transfer in progress |
| sp | output | 16 | Current stack pointer |
| memWe | output | 1 | Byte write strobe |
| memRe | output | 1 | Byte read strobe |
| memAddr | output | 16 | Byte address |
| memWdata | output | 8 | Byte to write |
| memRdata | input | 8 | Byte read back, same cycle as memRe |
| popValid | output | 1 | One-cycle pulse with a popped word |
| popData | output | 16 | Popped word |
| faultValid | output | 1 | One-cycle refusal pulse |
| faultCode | output | 2 | 1 overflow, 2 underflow |

## Verification
The bench goes after the window edges: the pointer at 0xFD02 refusing a frame push but taking a single push, the 129th push, and pops at 0xFE00 and frame pops at 0xFDFE. A design with an off-by-one bound would either write below the window or refuse its last legal slot, and one that checked a frame word by word would leave half a frame behind. Byte order is checked on the bus and through round trips, so swapped lanes show as swapped bytes. A request injected mid-transfer must leave no trace, which catches a controller that re-accepts while busy.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    OP_PUSH  = 2'd0,
    OP_POP   = 2'd1,
    OP_ENTER = 2'd2,
    OP_LEAVE = 2'd3
  } stkOp_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_OVER  = 2'd1,
    FLT_UNDER = 2'd2
  } stkFault_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_HI   = 2'd1,
    S_LO   = 2'd2
  } stkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch request words
    logic pair;     // request is a two-word frame
    logic spDec;    // pointer -= word size
    logic spInc;    // pointer += word size
    logic capHi;    // capture high byte of a read
    logic popDone;  // second byte of a read is on the bus
    logic wordSel;  // 0: first word, 1: second word
    logic lowLane;  // 0: high byte at pointer, 1: low byte at pointer+1
    logic wr;
    logic rd;
  } stkStrobe_t;

endpackage

// File: rtl/stk_dpath.sv
module stk_dpath
  import stk_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int LANE_W  = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE  = 16'hFD00,
  parameter int WIN_BYTES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  stkStrobe_t        str,
  input  logic [DATA_W-1:0] pushData,
  input  logic [DATA_W-1:0] pushFlags,
  input  logic [LANE_W-1:0] memRdata,
  output logic [ADDR_W-1:0] spOut,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANE_W-1:0] memWdata,
  output logic              popValid,
  output logic [DATA_W-1:0] popData,
  output logic              pushOk,
  output logic              pairPushOk,
  output logic              popOk,
  output logic              pairPopOk
);
  localparam int WORD_BYTES = DATA_W / LANE_W;
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] WIN_TOP  = WIN_BASE + ADDR_W'(WIN_BYTES);
  localparam logic [ADDR_W-1:0] PUSH_MIN = WIN_BASE + STEP;
  localparam logic [ADDR_W-1:0] PAIR_MIN = WIN_BASE + STEP + STEP;
  localparam logic [ADDR_W-1:0] PAIR_TOP = WIN_TOP - STEP;

  logic [ADDR_W-1:0] spReg;
  logic [DATA_W-1:0] word0, word1, curWord;
  logic [LANE_W-1:0] hiByte;

  // window bounds
  assign pushOk     = spReg >= PUSH_MIN;
  assign pairPushOk = spReg >= PAIR_MIN;
  assign popOk      = spReg <  WIN_TOP;
  assign pairPopOk  = spReg <  PAIR_TOP;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spReg <= WIN_TOP;
    end else if (str.spDec) begin
      spReg <= spReg - STEP;
    end else if (str.spInc) begin
      spReg <= spReg + STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      word0 <= '0;
      word1 <= '0;
    end else if (str.load) begin
      word0 <= str.pair ? pushFlags : pushData;
      word1 <= pushData;
    end
  end

  assign curWord  = str.wordSel ? word1 : word0;
  assign memAddr  = spReg + ADDR_W'(str.lowLane);
  assign memWdata = str.lowLane ? curWord[LANE_W-1:0] : curWord[DATA_W-1:DATA_W-LANE_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hiByte   <= '0;
      popData  <= '0;
      popValid <= 1'b0;
    end else begin
      popValid <= str.popDone;
      if (str.capHi) hiByte <= memRdata;
      if (str.popDone) popData <= {hiByte, memRdata};
    end
  end

  assign spOut = spReg;

  a_r2_push_step: assert property (@(posedge clk) disable iff (!rstN)
    str.spDec |=> spReg == $past(spReg) - STEP);

  a_r3_pop_step: assert property (@(posedge clk) disable iff (!rstN)
    str.popDone |=> popValid && spReg == $past(spReg) + STEP);

  a_r9_in_window: assert property (@(posedge clk) disable iff (!rstN)
    spReg[0] == 1'b0 && spReg >= WIN_BASE && spReg <= WIN_TOP);

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       pushOk,
  input  logic       pairPushOk,
  input  logic       popOk,
  input  logic       pairPopOk,
  output stkStrobe_t str,
  output logic       busy,
  output logic       faultValid,
  output logic [1:0] faultCode
);
  stkState_e state;
  logic      isPop, isPair, wordSel;
  logic      reqIsPop, reqIsPair, fitOk, accept, refuse;

  assign reqIsPop  = reqOp[0];
  assign reqIsPair = reqOp[1];
  assign fitOk  = reqIsPop ? (reqIsPair ? pairPopOk  : popOk)
                           : (reqIsPair ? pairPushOk : pushOk);
  assign accept = (state == S_IDLE) && reqValid && fitOk;
  assign refuse = (state == S_IDLE) && reqValid && !fitOk;
  assign busy   = (state != S_IDLE);

  always_comb begin
    str         = '0;
    str.load    = accept;
    str.pair    = reqIsPair;
    str.spDec   = accept && !reqIsPop;
    str.wordSel = wordSel;
    unique case (state)
      S_HI: begin
        str.wr    = !isPop;
        str.rd    = isPop;
        str.capHi = isPop;
      end
      S_LO: begin
        str.lowLane = 1'b1;
        str.wr      = !isPop;
        str.rd      = isPop;
        str.popDone = isPop;
        str.spInc   = isPop;
        if (!isPop && isPair && !wordSel) str.spDec = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      isPop      <= 1'b0;
      isPair     <= 1'b0;
      wordSel    <= 1'b0;
      faultValid <= 1'b0;
      faultCode  <= FLT_NONE;
    end else begin
      faultValid <= refuse;
      faultCode  <= refuse ? (reqIsPop ? FLT_UNDER : FLT_OVER) : FLT_NONE;
      unique case (state)
        S_IDLE: if (accept) begin
          state   <= S_HI;
          isPop   <= reqIsPop;
          isPair  <= reqIsPair;
          wordSel <= 1'b0;
        end
        S_HI: state <= S_LO;
        S_LO: begin
          if (isPair && !wordSel) begin
            wordSel <= 1'b1;
            state   <= S_HI;
          end else begin
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r4_refuse_quiet: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> !busy && !str.wr && !str.rd);

  a_r5_fault_code: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> (faultCode == FLT_OVER || faultCode == FLT_UNDER));

  a_r2_lane_order: assert property (@(posedge clk) disable iff (!rstN)
    (str.wr || str.rd) && !str.lowLane |=> (str.wr || str.rd) && str.lowLane);

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    busy && reqValid |-> !str.load);

endmodule

// File: rtl/stk_unit.sv
module stk_unit
  import stk_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 16,
  parameter int LANE_W    = 8,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFD00,
  parameter int WIN_BYTES = 256
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        reqOp,
  input  logic [DATA_W-1:0] pushData,
  input  logic [DATA_W-1:0] pushFlags,
  output logic              busy,
  output logic [ADDR_W-1:0] sp,
  output logic              memWe,
  output logic              memRe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [LANE_W-1:0] memWdata,
  input  logic [LANE_W-1:0] memRdata,
  output logic              popValid,
  output logic [DATA_W-1:0] popData,
  output logic              faultValid,
  output logic [1:0]        faultCode
);
  stkStrobe_t str;
  logic pushOk, pairPushOk, popOk, pairPopOk;

  stk_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .pushOk(pushOk), .pairPushOk(pairPushOk), .popOk(popOk), .pairPopOk(pairPopOk),
    .str(str), .busy(busy), .faultValid(faultValid), .faultCode(faultCode)
  );

  stk_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W),
    .WIN_BASE(WIN_BASE), .WIN_BYTES(WIN_BYTES)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .str(str), .pushData(pushData), .pushFlags(pushFlags),
    .memRdata(memRdata), .spOut(sp), .memAddr(memAddr), .memWdata(memWdata),
    .popValid(popValid), .popData(popData), .pushOk(pushOk), .pairPushOk(pairPushOk),
    .popOk(popOk), .pairPopOk(pairPopOk)
  );

  assign memWe = str.wr;
  assign memRe = str.rd;

  a_r4_sp_hold: assert property (@(posedge clk) disable iff (!rstN)
    faultValid |-> $stable(sp));

  a_r8_busy_covers_bus: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || memRe) |-> busy);

endmodule

// File: tb/sim_stk_unit.sv
module sim_stk_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqOp = 2'd0;
  logic [15:0] pushData = '0, pushFlags = '0;
  logic        busy, memWe, memRe, popValid, faultValid;
  logic [15:0] sp, memAddr, popData;
  logic [7:0]  memWdata, memRdata;
  logic [1:0]  faultCode;

  always #5 clk = ~clk;

  stk_unit u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .pushData(pushData), .pushFlags(pushFlags), .busy(busy), .sp(sp),
    .memWe(memWe), .memRe(memRe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .popValid(popValid), .popData(popData),
    .faultValid(faultValid), .faultCode(faultCode)
  );

  logic [7:0] mem [512];
  always @(posedge clk) if (memWe) mem[memAddr[8:0]] <= memWdata;
  assign memRdata = mem[memAddr[8:0]];

  int nChk = 0, nFail = 0;
  logic        gotFault;
  logic [1:0]  gotCode;
  int          nPop, nWe;
  logic [15:0] pops [2];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one request; collect fault, pops and write strobes until idle
  task automatic run(input logic [1:0] op, input logic [15:0] f, input logic [15:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqOp = op; pushFlags = f; pushData = d;
    @(negedge clk);
    reqValid = 1'b0;
    gotFault = faultValid; gotCode = faultCode; nPop = 0; nWe = 0;
    for (int i = 0; i < 16; i++) begin
      if (popValid) begin
        if (nPop < 2) pops[nPop] = popData;
        nPop++;
      end
      if (memWe || memRe) nWe++;
      if (!busy) break;
      @(negedge clk);
    end
  endtask

  // op, flags, data, expSp, pop0, pop1, code
  localparam bit [83:0] VEC [8] = '{
    {2'd0, 16'h0000, 16'h1234, 16'hFDFE, 16'h0000, 16'h0000, 2'd0},
    {2'd0, 16'h0000, 16'hABCD, 16'hFDFC, 16'h0000, 16'h0000, 2'd0},
    {2'd1, 16'h0000, 16'h0000, 16'hFDFE, 16'hABCD, 16'h0000, 2'd0},
    {2'd2, 16'h0013, 16'h4000, 16'hFDFA, 16'h0000, 16'h0000, 2'd0},
    {2'd3, 16'h0000, 16'h0000, 16'hFDFE, 16'h4000, 16'h0013, 2'd0},
    {2'd1, 16'h0000, 16'h0000, 16'hFE00, 16'h1234, 16'h0000, 2'd0},
    {2'd1, 16'h0000, 16'h0000, 16'hFE00, 16'h0000, 16'h0000, 2'd2},
    {2'd3, 16'h0000, 16'h0000, 16'hFE00, 16'h0000, 16'h0000, 2'd2}
  };

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(sp == 16'hFE00, "R1 sp", sp, 16'hFE00);
    chk(!busy && !faultValid && !popValid, "R1 idle", {busy, faultValid, popValid}, 0);

    // table walk: R2 R3 R5 R6 R7
    for (int v = 0; v < 8; v++) begin
      logic [1:0] op;
      int expPops;
      op = VEC[v][83:82];
      run(op, VEC[v][81:66], VEC[v][65:50]);
      expPops = (VEC[v][1:0] != 0) ? 0 : (op == 2'd1) ? 1 : (op == 2'd3) ? 2 : 0;
      chk(sp == VEC[v][49:34], $sformatf("R2/R3/R6/R7 vec%0d sp", v), sp, VEC[v][49:34]);
      chk(gotCode == VEC[v][1:0] && gotFault == (VEC[v][1:0] != 0),
          $sformatf("R5 vec%0d fault", v), {gotFault, gotCode}, VEC[v][1:0]);
      chk(nPop == expPops, $sformatf("R3 vec%0d pop count", v), nPop, expPops);
      if (expPops >= 1) chk(pops[0] == VEC[v][33:18], $sformatf("R3/R7 vec%0d word0", v), pops[0], VEC[v][33:18]);
      if (expPops == 2) chk(pops[1] == VEC[v][17:2], $sformatf("R7 vec%0d word1", v), pops[1], VEC[v][17:2]);
      if (VEC[v][1:0] != 0) chk(nWe == 0, $sformatf("R5 vec%0d no access", v), nWe, 0);
    end

    // R6 frame layout in memory: flags first (higher), return address second
    run(2'd2, 16'h0013, 16'h4000);
    chk({mem[9'h1FE], mem[9'h1FF]} == 16'h0013, "R6 flags big-endian", {mem[9'h1FE], mem[9'h1FF]}, 16'h0013);
    chk({mem[9'h1FC], mem[9'h1FD]} == 16'h4000, "R6 pc big-endian", {mem[9'h1FC], mem[9'h1FD]}, 16'h4000);
    run(2'd3, 0, 0);
    chk(sp == 16'hFE00, "R7 sp restored", sp, 16'hFE00);

    // R2 byte lanes on the bus, R8 request while busy is ignored
    @(negedge clk);
    reqValid = 1'b1; reqOp = 2'd0; pushData = 16'h7788;
    @(negedge clk);
    reqValid = 1'b0;
    chk(memWe && memAddr == 16'hFDFE && memWdata == 8'h77, "R2 high lane", {memWe, memAddr, memWdata}, {1'b1, 16'hFDFE, 8'h77});
    chk(busy, "R8 busy", busy, 1);
    reqValid = 1'b1; reqOp = 2'd1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(memWe && memAddr == 16'hFDFF && memWdata == 8'h88, "R2 low lane", {memWe, memAddr, memWdata}, {1'b1, 16'hFDFF, 8'h88});
    @(negedge clk);
    chk(!busy && !popValid && sp == 16'hFDFE, "R8 ignored while busy", {busy, popValid, sp}, {2'b00, 16'hFDFE});
    // R5 frame pop at 0xFDFE refused whole
    run(2'd3, 0, 0);
    chk(gotFault && gotCode == 2'd2 && nWe == 0 && sp == 16'hFDFE, "R5 frame pop refused", {gotCode, sp}, {2'd2, 16'hFDFE});
    run(2'd1, 0, 0);
    chk(nPop == 1 && pops[0] == 16'h7788, "R3 round trip", pops[0], 16'h7788);

    // R9 fill to 127, frame push refused at 0xFD02, last slot, overflow
    for (int k = 0; k < 127; k++) run(2'd0, 0, 16'(k * 3 + 7));
    chk(sp == 16'hFD02, "R9 sp at 127", sp, 16'hFD02);
    run(2'd2, 16'h1111, 16'h2222);
    chk(gotFault && gotCode == 2'd1 && nWe == 0 && sp == 16'hFD02, "R6 frame overflow", {gotCode, sp}, {2'd1, 16'hFD02});
    run(2'd0, 0, 16'(127 * 3 + 7));
    chk(!gotFault && sp == 16'hFD00, "R9 128th push", sp, 16'hFD00);
    run(2'd0, 0, 16'hDEAD);
    chk(gotFault && gotCode == 2'd1 && nWe == 0 && sp == 16'hFD00, "R4 129th push", {gotCode, sp}, {2'd1, 16'hFD00});
    @(negedge clk);
    chk(!faultValid, "R4 one-cycle pulse", faultValid, 0);
    begin
      int bad = 0;
      for (int k = 127; k >= 0; k--) begin
        run(2'd1, 0, 0);
        if (nPop != 1 || pops[0] != 16'(k * 3 + 7)) bad++;
      end
      chk(bad == 0, "R9 drain order", bad, 0);
    end
    chk(sp == 16'hFE00, "R9 drained", sp, 16'hFE00);
    run(2'd1, 0, 0);
    chk(gotFault && gotCode == 2'd2 && nWe == 0 && sp == 16'hFE00, "R5 extra pop", {gotCode, sp}, {2'd2, 16'hFE00});

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule